// File: doc/BRIEF.md
# Inter-Processor Mailbox Interrupt Unit

This unit lets the cores of a four-core cluster signal each other. Each core owns four 32-bit mailboxes, sixteen in all. Any bus master can flag bits in a mailbox through that mailbox's set address. The owning core removes the flags it has handled through the matching clear address. A mailbox raises its interrupt condition while it holds any nonzero bit.

Each core has an 8-bit control register. It holds a normal-interrupt (IRQ) enable and a fast-interrupt (FIQ) enable for each of that core's mailboxes. A mailbox whose FIQ enable is set is sent to the core's FIQ line only, whatever its IRQ enable holds. Both interrupt lines are registered. Read-only status words report which mailboxes currently drive each line.

The register bus is a plain one: address, write data, write enable and read data. A write takes effect at the clock edge where the enable is high. Read data is a combinational function of the address and the stored state.

Top module: `mbox_irq_unit`

## Requirements
- R1: Reset clears every mailbox and every control register. While reset is held and after it ends, `irqOut`, `fiqOut`, `mboxPend` and all register reads are zero.
- R2: A write to set address 0x080 + 16*c + 4*m ORs the ones of the write data into mailbox m of core c. Bits written as zero leave that mailbox unchanged.
- R3: A write to clear address 0x0C0 + 16*c + 4*m clears the bits of that mailbox where the write data is one. Bits written as zero leave that mailbox unchanged.
- R4: A read from either the set address or the clear address of a mailbox returns its current 32-bit contents.
- R5: `mboxPend[4*c+m]` is high whenever mailbox m of core c holds any nonzero bit. It changes right after the clock edge that writes the mailbox.
- R6: The control register of core c is at 0x050 + 4*c. Bit m (0..3) is the IRQ enable of mailbox m and bit 4+m is its FIQ enable. A read returns these 8 bits, and bits 31:8 read as zero.
- R7: `irqOut[c]` is high one cycle after some mailbox m of core c is pending with its IRQ enable set and its FIQ enable clear. It is a registered output, so it holds the old value in the cycle right after the triggering write.
- R8: `fiqOut[c]` is high one cycle after some mailbox m of core c is pending with its FIQ enable set. Such a mailbox never contributes to `irqOut[c]`.
- R9: A read of 0x060 + 4*c returns the mailboxes of core c that are routed to IRQ, with mailbox m on bit 4+m. A read of 0x070 + 4*c returns the mailboxes routed to FIQ in the same bit positions. All other bits read as zero.
- R10: A write to an address that maps to no register (for example 0x000 or 0x044) changes no mailbox and no enable, and a read from such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the register access |
| busWrData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe, sampled at the rising edge |
| busRdData | output | 32 | Read data for `busAddr` |
| irqOut | output | 4 | Registered IRQ line, one per core |
| fiqOut | output | 4 | Registered FIQ line, one per core |
| mboxPend | output | 16 | Mailbox-nonzero flags, core c on bits 4c+3:4c |

## Verification
The mailboxes are driven with overlapping set patterns to show OR accumulation, and with partial and full clears to tell clear-by-ones apart from overwrite. Enable patterns are IRQ-only, FIQ plus IRQ on the same mailbox, and FIQ-only on different cores. Together they separate plain enabling from FIQ steering, and they check that each core's line responds only to its own mailboxes. The IRQ line is sampled in the cycle right after a write and again one cycle later, which exposes a wrong latency. Writes to unmapped addresses are followed by readback and pending checks, which show whether a stray decode hit occurred.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  localparam int NUM_CORES     = 4;
  localparam int MBOX_PER_CORE = 4;
  localparam int NUM_MBOX      = NUM_CORES * MBOX_PER_CORE;
  localparam int DATA_W        = 32;
  localparam int ADDR_W        = 8;

  // one-hot register selects produced by the decoder
  typedef struct packed {
    logic [NUM_MBOX-1:0]  setHit;
    logic [NUM_MBOX-1:0]  clrHit;
    logic [NUM_MBOX-1:0]  rdMbox;
    logic [NUM_CORES-1:0] ctrlWr;
    logic [NUM_CORES-1:0] rdCtrl;
    logic [NUM_CORES-1:0] rdIrqSt;
    logic [NUM_CORES-1:0] rdFiqSt;
  } strobeT;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_irq_pkg::*;
#(
  parameter int AW          = ADDR_W,
  parameter int CORES       = NUM_CORES,
  parameter int PER_CORE    = MBOX_PER_CORE,
  parameter int CTRL_BASE   = 'h050,
  parameter int IRQST_BASE  = 'h060,
  parameter int FIQST_BASE  = 'h070,
  parameter int SET_BASE    = 'h080,
  parameter int CLR_BASE    = 'h0C0
) (
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  output strobeT        stb
);
  localparam int CORE_STRIDE = PER_CORE * 4;
  localparam int TOTAL       = CORES * PER_CORE;

  logic [TOTAL-1:0] setAddr, clrAddr;
  logic [CORES-1:0] ctrlAddr, irqStAddr, fiqStAddr;

  for (genvar c = 0; c < CORES; c++) begin : g_core
    assign ctrlAddr[c]  = (busAddr == AW'(CTRL_BASE  + 4 * c));
    assign irqStAddr[c] = (busAddr == AW'(IRQST_BASE + 4 * c));
    assign fiqStAddr[c] = (busAddr == AW'(FIQST_BASE + 4 * c));
    for (genvar m = 0; m < PER_CORE; m++) begin : g_mb
      localparam int IDX = c * PER_CORE + m;
      assign setAddr[IDX] = (busAddr == AW'(SET_BASE + c * CORE_STRIDE + 4 * m));
      assign clrAddr[IDX] = (busAddr == AW'(CLR_BASE + c * CORE_STRIDE + 4 * m));
    end
  end

  always_comb begin
    stb.setHit  = setAddr & {TOTAL{busWrEn}};
    stb.clrHit  = clrAddr & {TOTAL{busWrEn}};
    stb.rdMbox  = setAddr | clrAddr;
    stb.ctrlWr  = ctrlAddr & {CORES{busWrEn}};
    stb.rdCtrl  = ctrlAddr;
    stb.rdIrqSt = irqStAddr;
    stb.rdFiqSt = fiqStAddr;
  end
endmodule

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_irq_pkg::*;
#(
  parameter int DW       = DATA_W,
  parameter int CORES    = NUM_CORES,
  parameter int PER_CORE = MBOX_PER_CORE,
  parameter int STAT_LSB = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobeT                    stb,
  input  logic [DW-1:0]             wrData,
  output logic [DW-1:0]             rdData,
  output logic [CORES-1:0]          irqOut,
  output logic [CORES-1:0]          fiqOut,
  output logic [CORES*PER_CORE-1:0] mboxPend
);
  localparam int TOTAL  = CORES * PER_CORE;
  localparam int CTRL_W = 2 * PER_CORE;

  logic [DW-1:0]       mbox    [TOTAL];
  logic [CTRL_W-1:0]   ctrlReg [CORES];
  logic [PER_CORE-1:0] irqSt   [CORES];
  logic [PER_CORE-1:0] fiqSt   [CORES];

  for (genvar i = 0; i < TOTAL; i++) begin : g_mbox
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                mbox[i] <= '0;
      else if (stb.setHit[i])   mbox[i] <= mbox[i] | wrData;
      else if (stb.clrHit[i])   mbox[i] <= mbox[i] & ~wrData;
    end
    assign mboxPend[i] = |mbox[i];
  end

  for (genvar c = 0; c < CORES; c++) begin : g_core
    logic [PER_CORE-1:0] pendC, irqEn, fiqEn;
    assign pendC    = mboxPend[c*PER_CORE +: PER_CORE];
    assign irqEn    = ctrlReg[c][PER_CORE-1:0];
    assign fiqEn    = ctrlReg[c][CTRL_W-1:PER_CORE];
    assign fiqSt[c] = pendC & fiqEn;
    assign irqSt[c] = pendC & irqEn & ~fiqEn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlReg[c] <= '0;
        irqOut[c]  <= 1'b0;
        fiqOut[c]  <= 1'b0;
      end else begin
        if (stb.ctrlWr[c]) ctrlReg[c] <= wrData[CTRL_W-1:0];
        irqOut[c] <= |irqSt[c];
        fiqOut[c] <= |fiqSt[c];
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < TOTAL; i++)
      if (stb.rdMbox[i]) rdData = rdData | mbox[i];
    for (int c = 0; c < CORES; c++) begin
      if (stb.rdCtrl[c])  rdData = rdData | DW'(ctrlReg[c]);
      if (stb.rdIrqSt[c]) rdData = rdData | (DW'(irqSt[c]) << STAT_LSB);
      if (stb.rdFiqSt[c]) rdData = rdData | (DW'(fiqSt[c]) << STAT_LSB);
    end
  end
endmodule

// File: rtl/mbox_irq_unit.sv
module mbox_irq_unit
  import mbox_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic                busWrEn,
  output logic [DATA_W-1:0]   busRdData,
  output logic [NUM_CORES-1:0] irqOut,
  output logic [NUM_CORES-1:0] fiqOut,
  output logic [NUM_MBOX-1:0]  mboxPend
);
  strobeT stb;

  mbox_decode u_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .stb     (stb)
  );

  mbox_store u_store (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut),
    .mboxPend (mboxPend)
  );
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk
  import mbox_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busWrData,
  input logic                 busWrEn,
  input logic [DATA_W-1:0]    busRdData,
  input logic [NUM_CORES-1:0] irqOut,
  input logic [NUM_CORES-1:0] fiqOut,
  input logic [NUM_MBOX-1:0]  mboxPend
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rstN |=> (irqOut == '0 && fiqOut == '0 && mboxPend == '0));

  // R2
  set_marks_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h80 && busWrData != '0) |=> mboxPend[0]);

  // R3
  clr_all_drops_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'hC0 && busWrData == '1) |=> !mboxPend[0]);

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h00) |=> $stable(mboxPend));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    // R7
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[c] |-> $past(|mboxPend[c*MBOX_PER_CORE +: MBOX_PER_CORE]));
    // R8
    fiq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
      fiqOut[c] |-> $past(|mboxPend[c*MBOX_PER_CORE +: MBOX_PER_CORE]));
  end
endmodule

bind mbox_irq_unit mbox_irq_chk u_chk (.*);

// File: tb/tb_mbox_irq_unit.sv
`timescale 1ns/1ps
module tb_mbox_irq_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busRdData;
  logic [3:0]  irqOut, fiqOut;
  logic [15:0] mboxPend;

  mbox_irq_unit dut (.*);

  always #2 clk = ~clk;  // 250 MHz

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { int kind; logic [31:0] exp; string tag; } itemT;
  itemT q[$];

  logic [31:0] mdl [16];
  logic [7:0]  ctl [4];

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expIrq();
    logic [3:0] v = '0;
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++)
        if (mdl[c*4+m] != 0 && ctl[c][m] && !ctl[c][4+m]) v[c] = 1'b1;
    return v;
  endfunction

  function automatic logic [3:0] expFiq();
    logic [3:0] v = '0;
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++)
        if (mdl[c*4+m] != 0 && ctl[c][4+m]) v[c] = 1'b1;
    return v;
  endfunction

  function automatic logic [15:0] expPend();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) v[i] = (mdl[i] != 0);
    return v;
  endfunction

  function automatic logic [31:0] expStat(input int c, input bit fiq);
    logic [31:0] v = '0;
    for (int m = 0; m < 4; m++)
      if (mdl[c*4+m] != 0 && (fiq ? ctl[c][4+m] : (ctl[c][m] && !ctl[c][4+m])))
        v[4+m] = 1'b1;
    return v;
  endfunction

  // monitor: compares queued expectations one step after each rising edge
  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      itemT it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = busRdData;
        1:       act = {28'b0, irqOut};
        2:       act = {28'b0, fiqOut};
        default: act = {16'b0, mboxPend};
      endcase
      check(act, it.exp, it.tag);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic expectItem(input int kind, input logic [7:0] a,
                            input logic [31:0] e, input string tag);
    busAddr = a;
    q.push_back('{kind, e, tag});
    @(negedge clk);
  endtask

  task automatic mbSet(input int c, input int m, input logic [31:0] d);
    wr(8'(8'h80 + 16*c + 4*m), d);
    mdl[c*4+m] = mdl[c*4+m] | d;
  endtask

  task automatic mbClr(input int c, input int m, input logic [31:0] d);
    wr(8'(8'hC0 + 16*c + 4*m), d);
    mdl[c*4+m] = mdl[c*4+m] & ~d;
  endtask

  task automatic ctlWr(input int c, input logic [31:0] d);
    wr(8'(8'h50 + 4*c), d);
    ctl[c] = d[7:0];
  endtask

  task automatic checkLines(input string tag);
    expectItem(1, 8'h00, {28'b0, expIrq()}, {tag, " irq"});
    expectItem(2, 8'h00, {28'b0, expFiq()}, {tag, " fiq"});
    expectItem(3, 8'h00, {16'b0, expPend()}, {tag, " pend"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] oldIrq;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    for (int c = 0; c < 4; c++) ctl[c] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check({28'b0, irqOut}, 32'h0, "R1 irq in reset");
    check({16'b0, mboxPend}, 32'h0, "R1 pend in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkLines("R1 after reset");
    expectItem(0, 8'h80, 32'h0, "R1 mailbox read");
    expectItem(0, 8'h50, 32'h0, "R1 control read");

    // R2 / R4 / R5: set accumulates
    mbSet(1, 2, 32'h0000_00F0);
    expectItem(0, 8'h98, mdl[6], "R2 R4 set addr read");
    expectItem(0, 8'hD8, mdl[6], "R4 clr addr read");
    expectItem(3, 8'h00, {16'b0, expPend()}, "R5 pend after set");
    mbSet(1, 2, 32'h0000_0F00);
    expectItem(0, 8'h98, 32'h0000_0FF0, "R2 OR accumulate");

    // R6 / R7 / R9: IRQ routing
    oldIrq = expIrq();
    ctlWr(1, 32'h0000_0004);
    check({28'b0, irqOut}, {28'b0, oldIrq}, "R7 latency");
    checkLines("R7 irq enabled");
    expectItem(0, 8'h54, 32'h04, "R6 control read");
    expectItem(0, 8'h64, expStat(1, 0), "R9 irq status");
    expectItem(0, 8'h74, expStat(1, 1), "R9 fiq status empty");

    // R8 / R9: FIQ overrides IRQ
    ctlWr(1, 32'h0000_0044);
    checkLines("R8 fiq override");
    expectItem(0, 8'h74, 32'h40, "R9 fiq status");
    expectItem(0, 8'h64, 32'h00, "R9 irq status cleared");

    // R3 / R5: partial then full clear
    mbClr(1, 2, 32'h0000_00F0);
    expectItem(0, 8'hD8, 32'h0000_0F00, "R3 partial clear");
    checkLines("R3 R5 still pending");
    mbClr(1, 2, 32'hFFFF_FFFF);
    expectItem(0, 8'h98, 32'h0, "R3 full clear");
    checkLines("R3 R5 drained");

    // R7 / R8: other cores, own mailboxes only
    ctlWr(3, 32'h0000_0001);
    mbSet(3, 0, 32'h8000_0001);
    oldIrq = expIrq();
    ctlWr(0, 32'h0000_0080);
    mbSet(0, 3, 32'h0000_0100);
    checkLines("R7 R8 multi core");
    mbSet(2, 1, 32'h0000_0002);
    checkLines("R7 core2 not enabled");

    // R6: upper bits of control read zero
    ctlWr(2, 32'hFFFF_FFFF);
    expectItem(0, 8'h58, 32'h0000_00FF, "R6 upper bits zero");
    checkLines("R8 core2 fiq");

    // R10: unmapped writes and reads
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    expectItem(0, 8'h00, 32'h0, "R10 unmapped read");
    expectItem(0, 8'h44, 32'h0, "R10 unmapped read 44");
    checkLines("R10 no side effect");
    expectItem(0, 8'h8C, mdl[3], "R10 mailbox intact");
    expectItem(0, 8'h5C, 32'h01, "R10 control intact");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule